// File: doc/BRIEF.md
# Authentication Attempt Sequencer

This block runs challenge-triggered authentication attempts toward a slave on an attached serial bus and drives the two result pins. A challenge input is synchronised and watched in one of two senses, chosen by `cfg_chp`. Once a challenge is recognised, the block waits out a challenge delay and then runs up to `MAX_TRIES` tries. Each try has four phases: a bus exchange phase, three reset/presence slots, a strong-pullup delay and a strong-pullup computation window. After those phases it asks an external engine for a verdict. The engine answers on a `done`/`match` handshake. The bit-level bus signalling and the hash engine live outside this block. The block only marks which phase is active.

A matching verdict ends the attempt at once with PASS. If every permitted try fails, the attempt ends with FAIL. The two results are open-drain pull-down enables, so 1 means the pin is pulled low and 0 means it is released. The FAIL pin is either held low or blinked, depending on `cfg_fom`. Results persist until the next attempt starts. An oscillator-enable output models when the block may sleep.

The control is one state machine with seven states:

| State | Leaves to | When |
|---|---|---|
| `ST_IDLE` | `ST_CHAL_DLY` | a challenge is recognised |
| `ST_CHAL_DLY` | `ST_XCHG` | its timer expires |
| `ST_XCHG` | `ST_RSTPD` | its timer expires |
| `ST_RSTPD` | itself (next slot), or `ST_SPU_DLY` | a slot timer expires; it moves on after the third slot |
| `ST_SPU_DLY` | `ST_SPU_ON` | its timer expires |
| `ST_SPU_ON` | `ST_VERDICT` | its timer expires |
| `ST_VERDICT` | `ST_IDLE` with PASS | `done` with `match` |
| `ST_VERDICT` | `ST_IDLE` with FAIL | `done` without `match` on the last try |
| `ST_VERDICT` | `ST_XCHG` | `done` without `match` on any other try (retry) |

Every duration is a count of ticks. One tick is `PRESCALE` clocks. The tick timer restarts whenever the state changes and whenever a new reset slot begins.

Top module: `auth_attempt_seq`

## Requirements
- R1: After reset, all of `busy`, `bus_xchg`, `bus_rst_pulse`, `spu_en`, `eng_req`, `pass_pull` and `fail_pull` are 0.
- R2: With `cfg_chp`=1, a rising edge of `chal_in` starts an attempt, and a level already high through reset does not. With `cfg_chp`=0, a fall of `chal_in` to 0 starts an attempt, and a 0 held through reset counts as such a fall (a floating-low pin starts at power-up). In this mode a rise does not start an attempt.
- R3: `bus_xchg` rises exactly `CHD_TICKS*PRESCALE` clocks after `busy` rises.
- R4: Each try holds `bus_xchg` for `XCHG_TICKS*PRESCALE` clocks. Three reset slots follow, each `RST_TICKS*PRESCALE` clocks long. `bus_rst_pulse` is 1 for exactly the first clock of each slot.
- R5: `spu_en` rises `(RST_TICKS+SPUD_TICKS)*PRESCALE` clocks after the third slot pulse. It stays high for `SPUP_TICKS*PRESCALE` clocks, and `eng_req` follows immediately.
- R6: `eng_req` stays 1 until `eng_done` is seen. `eng_done` is ignored while `eng_req` is 0.
- R7: An attempt makes at most `MAX_TRIES` verdict requests. If none matches, it ends with `fail_pull`=1 and `pass_pull`=0.
- R8: A verdict with `eng_match`=1 on try k ends the attempt after exactly k requests, with `pass_pull`=1 and `fail_pull`=0.
- R9: With `cfg_fom`=0, `fail_pull` stays 1 after a failure. With `cfg_fom`=1, it starts at 1 and toggles every `BLINK_HALF_TICKS*PRESCALE` clocks.
- R10: `pass_pull` and `fail_pull` are never both 1. Both clear when the next attempt starts and hold until then.
- R11: A challenge that arrives while `busy`=1 is dropped. It does not start a further attempt after the current one ends.
- R12: `osc_en` = `busy` OR (challenge active AND NOT (`cfg_paa`=0 AND `cfg_ppt`=00 AND `cfg_fom`=0 AND first attempt completed)). The challenge is active when the synchronised `chal_in` is 1 with `cfg_chp`=1, or 0 with `cfg_chp`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chal_in | input | 1 | Challenge strobe (asynchronous) |
| cfg_chp | input | 1 | Challenge sense: 1 = rising edge, 0 = falling to active-low |
| cfg_fom | input | 1 | FAIL mode: 1 = blink, 0 = steady |
| cfg_paa | input | 1 | Sleep qualifier (blocks sleep when 1) |
| cfg_ppt | input | 2 | Sleep qualifier (blocks sleep when non-zero) |
| eng_done | input | 1 | Verdict valid |
| eng_match | input | 1 | Verdict: 1 = response matched |
| busy | output | 1 | Attempt in progress |
| bus_xchg | output | 1 | Bus exchange phase active |
| bus_rst_pulse | output | 1 | One-clock mark at the start of each reset/presence slot |
| spu_en | output | 1 | Strong pullup enable |
| eng_req | output | 1 | Verdict requested |
| pass_pull | output | 1 | PASS pin pull-down enable |
| fail_pull | output | 1 | FAIL pin pull-down enable |
| osc_en | output | 1 | Oscillator enable |

## Verification
Scripted verdict sequences check the retry logic:
- a match on the first try;
- a match on the third try;
- no match at all.

Each sequence separates stopping at the match from stopping at the try limit, and the count of requests shows which one happened.

Challenge patterns check the trigger logic:
- an edge after reset;
- a level held through reset in each sense;
- an edge made while the block is busy;
- a one-clock pulse.

Together they separate edge sensing from level sensing and accepted triggers from dropped ones.

Phase widths are measured in clocks to confirm that each timer restarts on its state. The sleep qualifiers are flipped one at a time to show that each one alone keeps the oscillator on.

// File: rtl/auth_seq_pkg.sv
package auth_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHAL_DLY,
        ST_XCHG,
        ST_RSTPD,
        ST_SPU_DLY,
        ST_SPU_ON,
        ST_VERDICT
    } seq_state_e;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/auth_chal_sense.sv
module auth_chal_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic chal_in,
    input  logic cfg_chp,
    output logic trig,
    output logic active
);
    // Three-stage history, reset high: a low pin after reset reads as a fall
    logic [2:0] hist;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist <= 3'b111;
        else        hist <= {hist[1:0], chal_in};
    end

    logic rose, fell;
    assign rose   = hist[1] & ~hist[2];
    assign fell   = ~hist[1] & hist[2];
    assign trig   = cfg_chp ? rose : fell;
    assign active = cfg_chp ? hist[1] : ~hist[1];

endmodule

// File: rtl/auth_phase_timer.sv
module auth_phase_timer #(
    parameter int PRESCALE = 2,
    parameter int TCW      = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic [TCW-1:0] limit,
    output logic           tick,
    output logic           done,
    output logic           first
);
    localparam int PCW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    logic [PCW-1:0] pc;
    logic [TCW-1:0] tc;

    assign tick  = (pc == PCW'(PRESCALE - 1));
    assign done  = tick && (tc == limit);
    assign first = (pc == '0) && (tc == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc <= '0;
            tc <= '0;
        end else if (clr) begin
            pc <= '0;
            tc <= '0;
        end else begin
            pc <= tick ? '0 : pc + PCW'(1);
            if (tick) tc <= (tc == limit) ? '0 : tc + TCW'(1);
        end
    end

    AST_TICK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        tc <= limit); // R3

endmodule

// File: rtl/auth_fail_blinker.sv
module auth_fail_blinker #(
    parameter int HALF = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic tick,
    output logic phase
);
    localparam int BCW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [BCW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            phase <= 1'b1;
        end else if (!active) begin
            cnt   <= '0;
            phase <= 1'b1;
        end else if (tick) begin
            if (cnt == BCW'(HALF - 1)) begin
                cnt   <= '0;
                phase <= ~phase;
            end else begin
                cnt <= cnt + BCW'(1);
            end
        end
    end

    AST_BLINK_REST: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> phase); // R9
    AST_BLINK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !tick) |=> $stable(phase)); // R9

endmodule

// File: rtl/auth_attempt_seq.sv
module auth_attempt_seq
    import auth_seq_pkg::*;
#(
    parameter int PRESCALE         = 50000,
    parameter int CHD_TICKS        = 65,
    parameter int XCHG_TICKS       = 24,
    parameter int RST_TICKS        = 1,
    parameter int SPUD_TICKS       = 6,
    parameter int SPUP_TICKS       = 34,
    parameter int BLINK_HALF_TICKS = 250,
    parameter int MAX_TRIES        = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chal_in,
    input  logic       cfg_chp,
    input  logic       cfg_fom,
    input  logic       cfg_paa,
    input  logic [1:0] cfg_ppt,
    input  logic       eng_done,
    input  logic       eng_match,
    output logic       busy,
    output logic       bus_xchg,
    output logic       bus_rst_pulse,
    output logic       spu_en,
    output logic       eng_req,
    output logic       pass_pull,
    output logic       fail_pull,
    output logic       osc_en
);
    localparam int MAXT = max2(max2(max2(CHD_TICKS, XCHG_TICKS), max2(RST_TICKS, SPUD_TICKS)),
                               SPUP_TICKS);
    localparam int TCW  = $clog2(MAXT + 1);
    localparam int TRW  = (MAX_TRIES > 1) ? $clog2(MAX_TRIES) : 1;
    localparam int NSLOT = 3;

    seq_state_e     state, state_n;
    logic [TCW-1:0] limit;
    logic           tmr_clr, tick, t_done, t_first;
    logic [TRW-1:0] try_cnt;
    logic [1:0]     slot_cnt;
    logic           pass_q, fail_q, init_done;
    logic           trig, chal_active, blink_ph;
    logic           last_try, start_att, verdict_take, slot_adv, sleep_hold;

    auth_chal_sense u_sense (
        .clk     (clk),
        .rst_n   (rst_n),
        .chal_in (chal_in),
        .cfg_chp (cfg_chp),
        .trig    (trig),
        .active  (chal_active)
    );

    auth_phase_timer #(.PRESCALE(PRESCALE), .TCW(TCW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .limit (limit),
        .tick  (tick),
        .done  (t_done),
        .first (t_first)
    );

    auth_fail_blinker #(.HALF(BLINK_HALF_TICKS)) u_blink (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (fail_q),
        .tick   (tick),
        .phase  (blink_ph)
    );

    assign last_try     = (try_cnt == TRW'(MAX_TRIES - 1));
    assign start_att    = (state == ST_IDLE) && trig;
    assign verdict_take = (state == ST_VERDICT) && eng_done;
    assign slot_adv     = (state == ST_RSTPD) && t_done && (slot_cnt != 2'(NSLOT - 1));

    // Tick limit (minus one) for the phase being timed
    always_comb begin
        unique case (state)
            ST_CHAL_DLY: limit = TCW'(CHD_TICKS - 1);
            ST_XCHG:     limit = TCW'(XCHG_TICKS - 1);
            ST_RSTPD:    limit = TCW'(RST_TICKS - 1);
            ST_SPU_DLY:  limit = TCW'(SPUD_TICKS - 1);
            ST_SPU_ON:   limit = TCW'(SPUP_TICKS - 1);
            default:     limit = '0;
        endcase
    end

    // Next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:     if (trig) state_n = ST_CHAL_DLY;
            ST_CHAL_DLY: if (t_done) state_n = ST_XCHG;
            ST_XCHG:     if (t_done) state_n = ST_RSTPD;
            ST_RSTPD:    if (t_done && !slot_adv) state_n = ST_SPU_DLY;
            ST_SPU_DLY:  if (t_done) state_n = ST_SPU_ON;
            ST_SPU_ON:   if (t_done) state_n = ST_VERDICT;
            ST_VERDICT: begin
                if (eng_done) begin
                    if (eng_match || last_try) state_n = ST_IDLE;
                    else                       state_n = ST_XCHG;
                end
            end
            default:     state_n = ST_IDLE;
        endcase
    end

    assign tmr_clr = (state_n != state) || slot_adv;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Try, slot and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            try_cnt   <= '0;
            slot_cnt  <= '0;
            pass_q    <= 1'b0;
            fail_q    <= 1'b0;
            init_done <= 1'b0;
        end else begin
            if (start_att) begin
                try_cnt <= '0;
                pass_q  <= 1'b0;
                fail_q  <= 1'b0;
            end
            if (state == ST_XCHG && t_done) slot_cnt <= '0;
            else if (slot_adv)              slot_cnt <= slot_cnt + 2'd1;
            if (verdict_take) begin
                if (eng_match) begin
                    pass_q    <= 1'b1;
                    init_done <= 1'b1;
                end else if (last_try) begin
                    fail_q    <= 1'b1;
                    init_done <= 1'b1;
                end else begin
                    try_cnt <= try_cnt + TRW'(1);
                end
            end
        end
    end

    // Outputs
    always_comb begin
        busy          = (state != ST_IDLE);
        bus_xchg      = (state == ST_XCHG);
        bus_rst_pulse = (state == ST_RSTPD) && t_first;
        spu_en        = (state == ST_SPU_ON);
        eng_req       = (state == ST_VERDICT);
        pass_pull     = pass_q;
        fail_pull     = fail_q && (!cfg_fom || blink_ph);
        sleep_hold    = !cfg_paa && (cfg_ppt == 2'b00) && !cfg_fom && init_done;
        osc_en        = busy || (chal_active && !sleep_hold);
    end

    AST_SLOT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        slot_cnt != 2'd3); // R4
    AST_SPU_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spu_en) |-> $past(state) == ST_SPU_DLY); // R5
    AST_VERDICT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && !eng_done) |=> eng_req); // R6
    AST_FAIL_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict_take && !eng_match && last_try) |=> (fail_q && state == ST_IDLE)); // R7
    AST_PASS_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict_take && eng_match) |=> (pass_q && state == ST_IDLE)); // R8
    AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_att |=> (!pass_q && !fail_q)); // R10
    AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass_q && fail_q)); // R10
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state != ST_CHAL_DLY) |=> state != ST_CHAL_DLY); // R11

endmodule

// File: tb/auth_attempt_seq_bench.sv
module auth_attempt_seq_bench;
    localparam int P    = 4;
    localparam int CHD  = 5;
    localparam int XCH  = 6;
    localparam int RST  = 3;
    localparam int SPUD = 2;
    localparam int SPUP = 4;
    localparam int HALF = 3;
    localparam int MAXT = 8;
    localparam int LAT  = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic chal_in = 1'b0, cfg_chp = 1'b1, cfg_fom = 1'b0, cfg_paa = 1'b0;
    logic [1:0] cfg_ppt = 2'b00;
    logic eng_done, eng_match;
    logic busy, bus_xchg, bus_rst_pulse, spu_en, eng_req, pass_pull, fail_pull, osc_en;

    int n_chk = 0, n_fail = 0;
    int tries = 0, attempt_base = 0, match_try = 0, stray_req = 0, stray_ack = 0;

    always #10 clk = ~clk;

    auth_attempt_seq #(
        .PRESCALE(P), .CHD_TICKS(CHD), .XCHG_TICKS(XCH), .RST_TICKS(RST),
        .SPUD_TICKS(SPUD), .SPUP_TICKS(SPUP), .BLINK_HALF_TICKS(HALF), .MAX_TRIES(MAXT)
    ) u_auth_attempt_seq (
        .clk(clk), .rst_n(rst_n), .chal_in(chal_in), .cfg_chp(cfg_chp), .cfg_fom(cfg_fom),
        .cfg_paa(cfg_paa), .cfg_ppt(cfg_ppt), .eng_done(eng_done), .eng_match(eng_match),
        .busy(busy), .bus_xchg(bus_xchg), .bus_rst_pulse(bus_rst_pulse), .spu_en(spu_en),
        .eng_req(eng_req), .pass_pull(pass_pull), .fail_pull(fail_pull), .osc_en(osc_en)
    );

    // Verdict responder: answers LAT negedges into a request; scripted match try
    initial begin
        int wait_cnt;
        wait_cnt  = 0;
        eng_done  = 1'b0;
        eng_match = 1'b0;
        forever begin
            @(negedge clk);
            if (stray_req != stray_ack) begin
                stray_ack = stray_req;
                eng_done  = 1'b1;
                eng_match = 1'b1;
            end else if (eng_req && !eng_done) begin
                wait_cnt++;
                if (wait_cnt >= LAT) begin
                    wait_cnt  = 0;
                    tries++;
                    eng_done  = 1'b1;
                    eng_match = ((tries - attempt_base) == match_try);
                end
            end else begin
                eng_done  = 1'b0;
                eng_match = 1'b0;
            end
        end
    end

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic chp, input logic lvl);
        rst_n = 1'b0; cfg_chp = chp; chal_in = lvl;
        cfg_fom = 1'b0; cfg_paa = 1'b0; cfg_ppt = 2'b00;
        step(3);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic pulse_chal();
        chal_in = 1'b0; step(3); chal_in = 1'b1;
    endtask

    task automatic wait_busy();
        int n = 0;
        while (!busy && n < 200) begin step(1); n++; end
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 5000) begin step(1); n++; end
    endtask

    task automatic arm(input int k);
        match_try = k; attempt_base = tries;
    endtask

    task automatic t_reset();
        do_reset(1'b1, 1'b0);
        chk("R1 busy", busy, 0);
        chk("R1 xchg/rst/spu/req", {bus_xchg, bus_rst_pulse, spu_en, eng_req}, 0);
        chk("R1 pass/fail", {pass_pull, fail_pull}, 0);
        step(4);
        chk("R12 osc off, challenge inactive", osc_en, 0);
    endtask

    task automatic t_edge_no_start();
        do_reset(1'b1, 1'b1);
        step(50);
        chk("R2 high through reset, edge mode: no start", busy, 0);
        chk("R12 osc on before first attempt", osc_en, 1);
    endtask

    task automatic t_timing();
        int n;
        arm(1);
        pulse_chal();
        wait_busy();
        n = 0; while (!bus_xchg && n < 500) begin step(1); n++; end
        chk("R3 challenge delay", n, CHD * P);
        n = 0; while (bus_xchg && n < 500) begin step(1); n++; end
        chk("R4 exchange width", n, XCH * P);
        chk("R4 first slot pulse", bus_rst_pulse, 1);
        for (int k = 0; k < 2; k++) begin
            n = 0;
            do begin step(1); n++; end while (!bus_rst_pulse && n < 500);
            chk("R4 slot spacing", n, RST * P);
        end
        n = 0; while (!spu_en && n < 500) begin step(1); n++; end
        chk("R5 pullup delay", n, (RST + SPUD) * P);
        n = 0; while (spu_en && n < 500) begin step(1); n++; end
        chk("R5 pullup width", n, SPUP * P);
        chk("R5 request follows", eng_req, 1);
        step(3);
        chk("R6 request held awaiting done", eng_req, 1);
        wait_idle();
        chk("R8 tries for first-try match", tries - attempt_base, 1);
        chk("R8 pass/fail after match", {pass_pull, fail_pull}, 2);
    endtask

    task automatic t_pass_third();
        arm(3);
        pulse_chal();
        wait_busy();
        while (!bus_xchg) step(1);
        stray_req++;
        step(3);
        chk("R6 stray done ignored, still busy", busy, 1);
        chk("R6 stray done ignored, no pass", pass_pull, 0);
        chal_in = 1'b0; step(3); chal_in = 1'b1;
        wait_idle();
        chk("R8 tries for third-try match", tries - attempt_base, 3);
        chk("R8 pass on third try", {pass_pull, fail_pull}, 2);
        step(60);
        chk("R11 busy-time challenge dropped", busy, 0);
        chk("R11 result unchanged", pass_pull, 1);
    endtask

    task automatic t_all_fail();
        int n;
        cfg_fom = 1'b0;
        arm(0);
        pulse_chal();
        wait_busy();
        chk("R10 pass cleared at start", pass_pull, 0);
        wait_idle();
        chk("R7 request count bounded", tries - attempt_base, MAXT);
        chk("R7 fail result", {pass_pull, fail_pull}, 1);
        n = 0;
        for (int i = 0; i < 40; i++) begin if (fail_pull) n++; step(1); end
        chk("R9 steady fail low", n, 40);
    endtask

    task automatic t_blink();
        int n;
        cfg_fom = 1'b1;
        arm(0);
        pulse_chal();
        wait_busy();
        chk("R10 fail cleared at start", {pass_pull, fail_pull}, 0);
        wait_idle();
        chk("R7 fail after all tries", tries - attempt_base, MAXT);
        n = 0; while (fail_pull && n < 100) begin n++; step(1); end
        chk("R9 blink first half", n, HALF * P);
        n = 0; while (!fail_pull && n < 100) begin n++; step(1); end
        chk("R9 blink second half", n, HALF * P);
        chk("R10 pass stays released", pass_pull, 0);
        cfg_fom = 1'b0;
        step(1);
        chk("R9 steady when mode cleared", fail_pull, 1);
    endtask

    task automatic t_level();
        arm(1);
        do_reset(1'b0, 1'b0);
        wait_busy();
        chk("R2 low through reset starts attempt", busy, 1);
        wait_idle();
        chk("R2 level attempt result", pass_pull, 1);
        chal_in = 1'b1; step(6);
        chk("R2 rise ignored in low mode", busy, 0);
        arm(1);
        chal_in = 1'b0;
        wait_busy();
        chk("R2 fall starts attempt", busy, 1);
        wait_idle();
    endtask

    task automatic t_osc();
        arm(1);
        do_reset(1'b1, 1'b0);
        pulse_chal();
        wait_busy();
        wait_idle();
        step(4);
        chk("R12 sleep when all qualifiers idle", osc_en, 0);
        cfg_paa = 1'b1; step(1);
        chk("R12 paa keeps osc", osc_en, 1);
        cfg_paa = 1'b0; cfg_ppt = 2'b01; step(1);
        chk("R12 ppt keeps osc", osc_en, 1);
        cfg_ppt = 2'b00; cfg_fom = 1'b1; step(1);
        chk("R12 fom keeps osc", osc_en, 1);
        cfg_fom = 1'b0; cfg_paa = 1'b1; chal_in = 1'b0; step(4);
        chk("R12 inactive challenge sleeps", osc_en, 0);
        cfg_paa = 1'b0;
        arm(1);
        chal_in = 1'b1; step(1); chal_in = 1'b0;
        wait_busy();
        step(2);
        chk("R12 busy keeps osc", osc_en, 1);
        wait_idle();
        step(4);
        chk("R12 sleep after attempt", osc_en, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_edge_no_start();
        t_timing();
        t_pass_third();
        t_all_fail();
        t_blink();
        t_level();
        t_osc();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule